// File: doc/BRIEF.md
# Fixed-Point Indexed Dot-Product Engine

This block computes the inner product of two vectors of signed 16-bit fixed-point numbers held in two separate memories. A start pulse latches a starting address for each vector, a fractional-bit count for each vector, and an element count. The engine then walks both memories in step, fetching one element pair per clock. It multiplies each pair on a single shared multiplier and adds the product into a 32-bit signed accumulator.

The memories sit outside the block behind a plain read port: an enable, one address per memory, and read data that returns one cycle after the enable. When the pipeline has drained, the engine pulses done. At the same time it presents the sum and the fractional-bit count of that sum. Products are added without any rescaling, so that count is the sum of the two operand counts. The block is the arithmetic core of a classifier. The surrounding decision logic and memory loading belong to other blocks.

Top module: `dpe_top`

## Requirements
- R1: `dot_o` equals the sum of `A[(base_a+k) mod D] * B[(base_b+k) mod D]` for k = 0 to n-1, where A and B are signed 16-bit and D = 2^ADDR_W.
- R2: The two base addresses are independent, and each address sequence wraps modulo 2^ADDR_W.
- R3: `fbits_o` equals `fbits_a_i + fbits_b_i`, computed to FRAC_W+1 bits with no overflow.
- R4: Exactly n read enables are issued, on consecutive cycles, with each address one above the previous. A requested count above MAX_N is clamped to MAX_N.
- R5: Take the clock edge that accepts start as edge 0. For n >= 1, done rises n+3 edges later. For n = 0, done rises at edge 1 and the result is 0.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: A start that arrives while a computation is in progress is ignored. It does not change the result, the latency, or the number of reads, and it produces no second done.
- R8: `dot_o` and `fbits_o` are 0 after reset. They change only in the cycle in which `done_o` is high.
- R9: The accumulator wraps on overflow in 32-bit two's complement, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| base_a_i | input | ADDR_W | First address of vector A |
| base_b_i | input | ADDR_W | First address of vector B |
| fbits_a_i | input | FRAC_W | Fractional bits of vector A |
| fbits_b_i | input | FRAC_W | Fractional bits of vector B |
| count_i | input | CNT_W | Number of element pairs |
| mem_rd_o | output | 1 | Read enable for both memories |
| addr_a_o | output | ADDR_W | Read address, memory A |
| addr_b_o | output | ADDR_W | Read address, memory B |
| data_a_i | input | DATA_W | Read data A, one cycle after enable |
| data_b_i | input | DATA_W | Read data B, one cycle after enable |
| done_o | output | 1 | One-cycle completion pulse |
| dot_o | output | ACC_W | Signed dot product |
| fbits_o | output | FRAC_W+1 | Fractional bits of the result |

## Verification
The bench builds the engine with ADDR_W = 6 and MAX_N = 40, keeping DATA_W = 16 and ACC_W = 32. The small address space means that random base addresses near the top of memory wrap within a single run. The reduced maximum length lets a count above MAX_N be requested, which exercises the clamp; the count port is 6 bits wide, so it can still reach 63. Vectors filled with the largest positive operand overflow the 32-bit accumulator within a few products, which exercises the wrap.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } dpe_state_e;
endpackage

// File: rtl/dpe_ctrl.sv
module dpe_ctrl
  import dpe_pkg::*;
#(
  parameter int MAX_N = 256,
  parameter int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pipe_busy_i,
  output logic             accept_o,
  output logic             issue_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             idle_o,
  output logic             finish_o
);
  localparam logic [CNT_W-1:0] LenMax = CNT_W'(MAX_N);

  dpe_state_e       state_q, state_d;
  logic [CNT_W-1:0] k_q, k_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] len_clamp;

  assign len_clamp = (count_i > LenMax) ? LenMax : count_i;

  always_comb begin
    state_d  = state_q;
    k_d      = k_q;
    len_d    = len_q;
    accept_o = 1'b0;
    issue_o  = 1'b0;
    finish_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          len_d    = len_clamp;
          k_d      = '0;
          state_d  = (len_clamp == '0) ? ST_DRAIN : ST_RUN;
        end
      end
      ST_RUN: begin
        issue_o = 1'b1;
        k_d     = k_q + 1'b1;
        if (k_q == len_q - 1'b1) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!pipe_busy_i) begin
          finish_o = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o || issue_o) k_q <= k_d;
      if (accept_o) len_q <= len_d;
    end
  end

  assign idx_o  = k_q;
  assign idle_o = (state_q == ST_IDLE);

  // R7: a start seen mid-run leaves the latched length untouched
  a_r7_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && start_i) |=> $stable(len_q));

  // R4: a run never issues beyond MAX_N reads
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> (k_q < LenMax));
endmodule

// File: rtl/dpe_addr.sv
module dpe_addr #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o
);
  logic [ADDR_W-1:0] base_a_q, base_b_q;
  logic [ADDR_W-1:0] offs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_b_q <= '0;
    end else if (load_i) begin
      base_a_q <= base_a_i;
      base_b_q <= base_b_i;
    end
  end

  assign offs     = ADDR_W'(idx_i);
  assign addr_a_o = base_a_q + offs;
  assign addr_b_o = base_b_q + offs;

  // R4, R2: back-to-back reads step both addresses by one, wrapping
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && $past(issue_i)) |->
      (addr_a_o == $past(addr_a_o) + 1'b1) && (addr_b_o == $past(addr_b_o) + 1'b1));
endmodule

// File: rtl/dpe_mac.sv
module dpe_mac #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output logic                     busy_o
);
  localparam int PROD_W = 2 * DATA_W;

  logic                     v1_q, v2_q;
  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic signed [ACC_W-1:0]  acc_d, acc_q;

  assign prod_d = a_i * b_i;
  assign acc_d  = acc_q + ACC_W'(prod_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      prod_q <= '0;
      acc_q  <= '0;
    end else begin
      v1_q <= vld_i;
      v2_q <= v1_q;
      if (v1_q) prod_q <= prod_d;
      if (clear_i)   acc_q <= '0;
      else if (v2_q) acc_q <= acc_d;
    end
  end

  assign acc_o  = acc_q;
  assign busy_o = v1_q | v2_q;

  // R9: with no product entering, the accumulator does not move
  a_r9_acc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!v2_q && !clear_i) |=> $stable(acc_q));
endmodule

// File: rtl/dpe_top.sv
module dpe_top #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10,
  parameter int FRAC_W = 8,
  parameter int MAX_N  = 256,
  parameter int CNT_W  = $clog2(MAX_N + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        base_a_i,
  input  logic [ADDR_W-1:0]        base_b_i,
  input  logic [FRAC_W-1:0]        fbits_a_i,
  input  logic [FRAC_W-1:0]        fbits_b_i,
  input  logic [CNT_W-1:0]         count_i,
  output logic                     mem_rd_o,
  output logic [ADDR_W-1:0]        addr_a_o,
  output logic [ADDR_W-1:0]        addr_b_o,
  input  logic signed [DATA_W-1:0] data_a_i,
  input  logic signed [DATA_W-1:0] data_b_i,
  output logic                     done_o,
  output logic signed [ACC_W-1:0]  dot_o,
  output logic [FRAC_W:0]          fbits_o
);
  logic [1:0]              rs_q;
  logic                    rst_sn;
  logic                    accept, issue, idle, finish, busy;
  logic [CNT_W-1:0]        idx;
  logic signed [ACC_W-1:0] acc;
  logic [FRAC_W:0]         fsum_q;
  logic                    done_q;
  logic signed [ACC_W-1:0] dot_q;
  logic [FRAC_W:0]         fbits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  dpe_ctrl #(.MAX_N(MAX_N), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .start_i(start_i), .count_i(count_i),
    .pipe_busy_i(busy), .accept_o(accept), .issue_o(issue), .idx_o(idx),
    .idle_o(idle), .finish_o(finish)
  );

  dpe_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_sn), .load_i(accept), .issue_i(issue),
    .base_a_i(base_a_i), .base_b_i(base_b_i), .idx_i(idx),
    .addr_a_o(addr_a_o), .addr_b_o(addr_b_o)
  );

  dpe_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_sn), .clear_i(accept), .vld_i(issue),
    .a_i(data_a_i), .b_i(data_b_i), .acc_o(acc), .busy_o(busy)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      fsum_q  <= '0;
      done_q  <= 1'b0;
      dot_q   <= '0;
      fbits_q <= '0;
    end else begin
      done_q <= finish;
      if (accept) fsum_q <= {1'b0, fbits_a_i} + {1'b0, fbits_b_i};
      if (finish) begin
        dot_q   <= acc;
        fbits_q <= fsum_q;
      end
    end
  end

  assign mem_rd_o = issue;
  assign done_o   = done_q;
  assign dot_o    = dot_q;
  assign fbits_o  = fbits_q;

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o);

  // R8: outputs move only alongside done
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !done_o |-> ($stable(dot_o) && $stable(fbits_o)));

  // R5: an empty request completes one edge after acceptance
  a_r5_zero_len: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle && start_i && count_i == '0) |=> ##1 done_o);

  // R5: done only after the multiply-accumulate pipeline is empty
  a_r5_drained: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> (!busy && !mem_rd_o));
endmodule

// File: tb/tb_dpe_top.sv
module tb_dpe_top;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 32;
  localparam int ADDR_W = 6;
  localparam int FRAC_W = 8;
  localparam int MAX_N  = 40;
  localparam int CNT_W  = $clog2(MAX_N + 1);
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [ADDR_W-1:0] base_a_i, base_b_i;
  logic [FRAC_W-1:0] fbits_a_i, fbits_b_i;
  logic [CNT_W-1:0]  count_i;
  logic mem_rd_o;
  logic [ADDR_W-1:0] addr_a_o, addr_b_o;
  logic signed [DATA_W-1:0] data_a_i, data_b_i;
  logic done_o;
  logic signed [ACC_W-1:0] dot_o;
  logic [FRAC_W:0] fbits_o;

  logic signed [DATA_W-1:0] mem_a [DEPTH];
  logic signed [DATA_W-1:0] mem_b [DEPTH];
  int rd_total = 0;
  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  dpe_top #(.DATA_W(DATA_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
            .MAX_N(MAX_N)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_a_i(base_a_i),
    .base_b_i(base_b_i), .fbits_a_i(fbits_a_i), .fbits_b_i(fbits_b_i),
    .count_i(count_i), .mem_rd_o(mem_rd_o), .addr_a_o(addr_a_o),
    .addr_b_o(addr_b_o), .data_a_i(data_a_i), .data_b_i(data_b_i),
    .done_o(done_o), .dot_o(dot_o), .fbits_o(fbits_o)
  );

  always @(posedge clk) begin
    if (mem_rd_o) begin
      data_a_i <= mem_a[addr_a_o];
      data_b_i <= mem_b[addr_b_o];
      rd_total <= rd_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int n);
    return (n > MAX_N) ? MAX_N : n;
  endfunction

  function automatic logic signed [31:0] model_dot(input int b1, input int b2, input int n);
    logic signed [31:0] s = 0;
    for (int k = 0; k < eff_len(n); k++)
      s = s + 32'(int'(mem_a[(b1 + k) % DEPTH]) * int'(mem_b[(b2 + k) % DEPTH]));
    return s;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < DEPTH; i++) begin
      mem_a[i] = DATA_W'($urandom);
      mem_b[i] = DATA_W'($urandom);
    end
  endtask

  task automatic run(input int b1, input int b2, input int f1, input int f2,
                     input int n, input bit intrude);
    logic signed [31:0] exp_dot;
    int exp_lat, cyc, rd0;
    exp_dot = model_dot(b1, b2, n);
    exp_lat = (eff_len(n) == 0) ? 1 : eff_len(n) + 3;
    rd0 = rd_total;
    base_a_i = ADDR_W'(b1); base_b_i = ADDR_W'(b2);
    fbits_a_i = FRAC_W'(f1); fbits_b_i = FRAC_W'(f2);
    count_i = CNT_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 500) begin
      if (intrude && cyc == 2) begin
        base_a_i = ADDR_W'(b1 + 7); base_b_i = ADDR_W'(b2 + 3);
        fbits_a_i = 8'd1; count_i = CNT_W'(1);
        start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(dot_o == exp_dot, intrude ? "R7/R1 result" : "R1 result", dot_o, exp_dot);
    chk(fbits_o == 9'(f1 + f2), "R3 fbits", fbits_o, f1 + f2);
    chk(cyc - 1 == exp_lat, "R5 latency", cyc - 1, exp_lat);
    chk(rd_total - rd0 == eff_len(n), "R4 read count", rd_total - rd0, eff_len(n));
    @(negedge clk);
    chk(done_o == 1'b0, "R6 pulse width", done_o, 0);
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && dot_o == exp_dot, intrude ? "R7 no rerun" : "R8 hold",
        dot_o, exp_dot);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; start_i = 1'b0;
    base_a_i = '0; base_b_i = '0; fbits_a_i = '0; fbits_b_i = '0; count_i = '0;
    fill_random();
    repeat (3) @(negedge clk);
    chk(dot_o == 0 && fbits_o == 0 && done_o == 0, "R8 reset", dot_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_rd_o == 1'b0, "R4 idle reads", mem_rd_o, 0);

    run(5, 20, 3, 4, 8, 1'b0);              // R1, R2 distinct bases
    run(9, 9, 0, 0, 0, 1'b0);               // R5 zero length
    run(0, 63, 15, 15, 1, 1'b0);            // R1 single pair
    run(60, 55, 7, 9, 12, 1'b0);            // R2 both wrap
    run(11, 2, 8, 8, MAX_N, 1'b0);          // R4 full length
    run(30, 40, 2, 3, 63, 1'b0);            // R4 clamp to MAX_N
    run(14, 33, 255, 255, 10, 1'b0);        // R3 widest fbits
    run(3, 17, 4, 5, 9, 1'b1);              // R7 start during run

    for (int i = 0; i < DEPTH; i++) begin
      mem_a[i] = 16'sd32767;
      mem_b[i] = 16'sd32767;
    end
    run(0, 0, 15, 15, 3, 1'b0);             // R9 positive overflow wraps
    for (int i = 0; i < DEPTH; i++) mem_a[i] = -16'sd32768;
    run(0, 0, 15, 15, 5, 1'b0);             // R9 negative overflow wraps
    fill_random();

    for (int t = 0; t < 20; t++)
      run(int'($urandom % DEPTH), int'($urandom % DEPTH), int'($urandom % 256),
          int'($urandom % 256), int'($urandom % 64), t % 5 == 4);  // R1 random

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule